// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block takes 32 level-sensitive interrupt request lines and turns them into a single request for the CPU. Each request carries a handler address and the attributes of one line. A line can be raised by its hardware input or by a software-interrupt bit. A line takes part in arbitration only while its enable bit is set. Every line has its own configuration word, which holds a priority level, a register-set number and a non-maskable flag.

Every cycle the controller chooses the enabled, requesting line with the highest level. It then forms that line's handler address as an offset into a vector table. The table base and the entry size are both programmable. The controller registers a request packet holding the address, register set, level and flag, together with a request strobe.

Software programs the block through a 32-bit register port with word addressing. Writes take effect in a single cycle, and read data comes back in the cycle that follows the read.

Top module: `vpic_top`

## Requirements
- R1: A line is pending when (raw input bit OR software bit) AND enable bit. Word 35 reads the pending set. A line whose enable bit is clear never produces a request.
- R2: In a line configuration word, bits 5:0 hold the level, bit 6 holds the non-maskable flag and bits 12:7 hold the register set. The request packet carries these three fields from the winning line.
- R3: The winner is the pending line with the strictly highest level. On equal levels the lowest-numbered line wins. A pending line with level 0 never wins.
- R4: The handler address equals base + index * (1 << (2 + S)). Here S is bits 2:0 of the control word at offset 40, and base is the word at offset 42.
- R5: While a line is selected, the status word at offset 41 reads the line index in its low bits with bit 31 set. The computed-address word at offset 43 reads the handler address. With no winner, req_valid is 0 and every packet field, the status word and the address word are 0.
- R6: Enable sits at offset 32, with set and clear aliases at 33 and 34. The software-interrupt word sits at offset 37, with aliases at 38 and 39. A plain write replaces the word, a set write ORs the value in, and a clear write ANDs the word with the inverted value.
- R7: Offsets 0 to 31 are the per-line configuration words and read back bits 12:0 with zeros above. Offset 40 reads back bits 2:0. Offset 36 reads the raw input status. Reads of offsets 33, 34, 38 and 39, and of offsets 44 and up, return 0.
- R8: Writes to offsets 35, 36, 41, 43 and to offsets 44 and up change no state.
- R9: A synchronous active-high reset clears all configuration words, the enable, software, control and base words, and the packet and status outputs.
- R10: Raw inputs are sampled on every clock and the packet is registered. An input change reaches the packet after two rising edges. A register write reaches the packet at the edge after the write edge. Read data is valid in the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq_lines | input | 32 | Level-sensitive request inputs |
| req_valid | output | 1 | Request strobe to the CPU |
| req_addr | output | 32 | Handler address |
| req_regset | output | 6 | Requested register set |
| req_level | output | 6 | Requested level |
| req_nmi | output | 1 | Non-maskable request flag |

## Verification
The hardest cases to set up from the ports are the ones where several pending lines compete. These are two lines on the same level, and a requesting line that loses only because its level is zero or because it is disabled. The stimulus table programs lines with equal, zero and maximum levels and leaves one line disabled. It then drives input patterns that make these lines contend. Directed steps raise a line purely through the software aliases. They also change the entry size while a request is live, which shows the one-cycle update of the address.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int NUM_LINES = 32;
    localparam int DATA_W    = 32;
    localparam int LVL_W     = 6;
    localparam int RS_W      = 6;
    localparam int ADDR_W    = 6;
    localparam int SHIFT_W   = 3;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int CFG_W     = RS_W + 1 + LVL_W;

    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 6'd32;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 6'd33;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 6'd34;
    localparam logic [ADDR_W-1:0] OFS_PEND    = 6'd35;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 6'd36;
    localparam logic [ADDR_W-1:0] OFS_SOFT    = 6'd37;
    localparam logic [ADDR_W-1:0] OFS_SW_SET  = 6'd38;
    localparam logic [ADDR_W-1:0] OFS_SW_CLR  = 6'd39;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'd40;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 6'd41;
    localparam logic [ADDR_W-1:0] OFS_BASE    = 6'd42;
    localparam logic [ADDR_W-1:0] OFS_VADDR   = 6'd43;

    // field order sets bit positions: regset 12:7, nmi 6, level 5:0
    typedef struct packed {
        logic [RS_W-1:0]  regset;
        logic             nmi;
        logic [LVL_W-1:0] level;
    } line_cfg_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
        line_cfg_t        cfg;
    } winner_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] addr;
        logic [RS_W-1:0]   regset;
        logic [LVL_W-1:0]  level;
        logic              nmi;
    } req_pkt_t;

    function automatic logic [DATA_W-1:0] handler_addr(
        input logic [DATA_W-1:0]  base,
        input logic [IDX_W-1:0]   idx,
        input logic [SHIFT_W-1:0] shift
    );
        return base + (DATA_W'(idx) << (5'd2 + 5'(shift)));
    endfunction
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N-1:0]        irq_lines,
    input  logic [DATA_W-1:0]   status_word,
    input  logic [DATA_W-1:0]   vaddr_word,
    output line_cfg_t           cfg_o [N],
    output logic [N-1:0]        enable_o,
    output logic [N-1:0]        pending_o,
    output logic [SHIFT_W-1:0]  shift_o,
    output logic [DATA_W-1:0]   base_o
);
    line_cfg_t          cfg_q [N];
    logic [N-1:0]       raw_q, enable_q, soft_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [DATA_W-1:0]  base_q, rdata_q;

    wire do_wr  = bus_valid && bus_write;
    wire do_rd  = bus_valid && !bus_write;
    wire is_cfg = bus_addr < ADDR_W'(N);

    assign pending_o = (raw_q | soft_q) & enable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) cfg_q[i] <= '0;
            raw_q    <= '0;
            enable_q <= '0;
            soft_q   <= '0;
            shift_q  <= '0;
            base_q   <= '0;
        end else begin
            raw_q <= irq_lines;
            if (do_wr) begin
                if (is_cfg) begin
                    cfg_q[bus_addr[IDX_W-1:0]] <= line_cfg_t'(bus_wdata[CFG_W-1:0]);
                end else begin
                    case (bus_addr)
                        OFS_ENABLE: enable_q <= bus_wdata[N-1:0];
                        OFS_EN_SET: enable_q <= enable_q | bus_wdata[N-1:0];
                        OFS_EN_CLR: enable_q <= enable_q & ~bus_wdata[N-1:0];
                        OFS_SOFT:   soft_q   <= bus_wdata[N-1:0];
                        OFS_SW_SET: soft_q   <= soft_q | bus_wdata[N-1:0];
                        OFS_SW_CLR: soft_q   <= soft_q & ~bus_wdata[N-1:0];
                        OFS_CTRL:   shift_q  <= bus_wdata[SHIFT_W-1:0];
                        OFS_BASE:   base_q   <= bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= '0;
            if (do_rd) begin
                if (is_cfg) begin
                    rdata_q <= DATA_W'(cfg_q[bus_addr[IDX_W-1:0]]);
                end else begin
                    case (bus_addr)
                        OFS_ENABLE: rdata_q <= DATA_W'(enable_q);
                        OFS_PEND:   rdata_q <= DATA_W'(pending_o);
                        OFS_RAW:    rdata_q <= DATA_W'(raw_q);
                        OFS_SOFT:   rdata_q <= DATA_W'(soft_q);
                        OFS_CTRL:   rdata_q <= DATA_W'(shift_q);
                        OFS_STATUS: rdata_q <= status_word;
                        OFS_BASE:   rdata_q <= base_q;
                        OFS_VADDR:  rdata_q <= vaddr_word;
                        default:    rdata_q <= '0;
                    endcase
                end
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign cfg_o     = cfg_q;
    assign enable_o  = enable_q;
    assign shift_o   = shift_q;
    assign base_o    = base_q;
endmodule

// File: rtl/vpic_select.sv
module vpic_select
    import vpic_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic [N-1:0] pending,
    input  line_cfg_t    cfg [N],
    output winner_t      win
);
    always_comb begin
        win = '0;
        for (int i = 0; i < N; i++) begin
            // strict compare keeps the lower index on ties; level 0 never beats 0
            if (pending[i] && (cfg[i].level > win.cfg.level)) begin
                win.found = 1'b1;
                win.idx   = IDX_W'(i);
                win.cfg   = cfg[i];
            end
        end
    end
endmodule

// File: rtl/vpic_vector.sv
module vpic_vector
    import vpic_pkg::*;
(
    input  winner_t             win,
    input  logic [DATA_W-1:0]   base,
    input  logic [SHIFT_W-1:0]  shift,
    output req_pkt_t            pkt,
    output logic [DATA_W-1:0]   status
);
    always_comb begin
        pkt    = '0;
        status = '0;
        if (win.found) begin
            pkt.valid  = 1'b1;
            pkt.addr   = handler_addr(base, win.idx, shift);
            pkt.regset = win.cfg.regset;
            pkt.level  = win.cfg.level;
            pkt.nmi    = win.cfg.nmi;
            status[IDX_W-1:0] = win.idx;
            status[DATA_W-1]  = 1'b1;
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       irq_lines,
    output logic              req_valid,
    output logic [31:0]       req_addr,
    output logic [5:0]        req_regset,
    output logic [5:0]        req_level,
    output logic              req_nmi
);
    line_cfg_t             cfg_w [NUM_LINES];
    logic [NUM_LINES-1:0]  enable_w, pending_w;
    logic [SHIFT_W-1:0]    shift_w;
    logic [DATA_W-1:0]     base_w, status_d, status_q;
    winner_t               win_w;
    req_pkt_t              pkt_d, pkt_q;

    vpic_regs #(.N(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines),
        .status_word(status_q), .vaddr_word(pkt_q.addr),
        .cfg_o(cfg_w), .enable_o(enable_w), .pending_o(pending_w),
        .shift_o(shift_w), .base_o(base_w)
    );

    vpic_select #(.N(NUM_LINES)) u_sel (
        .pending(pending_w), .cfg(cfg_w), .win(win_w)
    );

    vpic_vector u_vec (
        .win(win_w), .base(base_w), .shift(shift_w),
        .pkt(pkt_d), .status(status_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q    <= '0;
            status_q <= '0;
        end else begin
            pkt_q    <= pkt_d;
            status_q <= status_d;
        end
    end

    assign req_valid  = pkt_q.valid;
    assign req_addr   = pkt_q.addr;
    assign req_regset = pkt_q.regset;
    assign req_level  = pkt_q.level;
    assign req_nmi    = pkt_q.nmi;
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [5:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic [31:0] enable,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [5:0]  req_regset,
    input logic [5:0]  req_level,
    input logic        req_nmi
);
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!req_valid && req_addr == '0 && req_level == '0));

    assert_idle_packet_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (req_addr == '0 && req_level == '0 && req_regset == '0 && !req_nmi));

    assert_level_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_level != '0));

    assert_disabled_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |=> !req_valid);

    assert_alias_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && (bus_addr == 6'd33 || bus_addr == 6'd39)) |=> (bus_rdata == '0));
endmodule

bind vpic_top vpic_checker u_chk (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .enable(enable_w),
    .req_valid(req_valid), .req_addr(req_addr), .req_regset(req_regset),
    .req_level(req_level), .req_nmi(req_nmi)
);

// File: tb/tb_vpic_top.sv
module tb_vpic_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] irq_lines = '0;
    logic        req_valid, req_nmi;
    logic [31:0] req_addr;
    logic [5:0]  req_regset, req_level;

    int errs = 0, checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vpic_top dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .req_valid(req_valid), .req_addr(req_addr),
        .req_regset(req_regset), .req_level(req_level), .req_nmi(req_nmi)
    );

    typedef struct packed {
        logic [31:0] irq;
        logic        vld;
        logic [31:0] addr;
        logic [5:0]  lvl;
        logic [5:0]  rs;
        logic        nmi;
    } vec_t;

    // lines: 3 lvl5 rs2; 7 lvl9 rs4 nmi; 10 lvl9 rs1; 20 lvl0; 25 lvl40 disabled; 31 lvl63 rs63 nmi
    // base 0x1000, entry 8 bytes
    localparam vec_t VECS [10] = '{
        '{32'h0000_0000, 1'b0, 32'h0,    6'd0,  6'd0,  1'b0},
        '{32'h0000_0008, 1'b1, 32'h1018, 6'd5,  6'd2,  1'b0},
        '{32'h0000_0088, 1'b1, 32'h1038, 6'd9,  6'd4,  1'b1},
        '{32'h0000_0480, 1'b1, 32'h1038, 6'd9,  6'd4,  1'b1},
        '{32'h0000_0400, 1'b1, 32'h1050, 6'd9,  6'd1,  1'b0},
        '{32'h0010_0000, 1'b0, 32'h0,    6'd0,  6'd0,  1'b0},
        '{32'h0200_0000, 1'b0, 32'h0,    6'd0,  6'd0,  1'b0},
        '{32'h8010_0488, 1'b1, 32'h10F8, 6'd63, 6'd63, 1'b1},
        '{32'h0210_0008, 1'b1, 32'h1018, 6'd5,  6'd2,  1'b0},
        '{32'h0000_0001, 1'b0, 32'h0,    6'd0,  6'd0,  1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_pkt(input string req, input logic v, input logic [31:0] a,
                           input logic [5:0] l, input logic [5:0] r, input logic n);
        chk({req, " valid"},  32'(req_valid),  32'(v));
        chk({req, " addr"},   req_addr,        a);
        chk({req, " level"},  32'(req_level),  32'(l));
        chk({req, " regset"}, 32'(req_regset), 32'(r));
        chk({req, " nmi"},    32'(req_nmi),    32'(n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk_pkt("R9 reset packet", 1'b0, 32'h0, 6'd0, 6'd0, 1'b0);
        rd(6'd41, d); chk("R9 reset status", d, 32'h0);

        wr(6'd3,  32'h105);
        wr(6'd7,  32'h249);
        wr(6'd10, 32'h089);
        wr(6'd20, 32'h180);
        wr(6'd25, 32'h028);
        wr(6'd31, 32'h1FFF);
        wr(6'd32, 32'hFDFF_FFFF);
        wr(6'd42, 32'h0000_1000);
        wr(6'd40, 32'h1);

        // table walk covering R1 R2 R3 R4 and input latency R10
        foreach (VECS[i]) begin
            @(negedge clk) irq_lines = VECS[i].irq;
            @(posedge clk);
            settle();
            chk_pkt($sformatf("R3 vec%0d", i), VECS[i].vld, VECS[i].addr,
                    VECS[i].lvl, VECS[i].rs, VECS[i].nmi);
        end
        @(negedge clk) irq_lines = '0;
        settle(); settle();

        // R2/R7 config readback and masking
        rd(6'd7, d); chk("R2 cfg7 readback", d, 32'h249);
        wr(6'd20, 32'hFFFF_FFFF);
        rd(6'd20, d); chk("R7 cfg mask", d, 32'h1FFF);
        wr(6'd20, 32'h180);

        // R6 enable aliases
        wr(6'd32, 32'h0);
        wr(6'd33, 32'h0000_0408);
        rd(6'd32, d); chk("R6 enable set", d, 32'h408);
        wr(6'd34, 32'h0000_0008);
        rd(6'd32, d); chk("R6 enable clear", d, 32'h400);
        rd(6'd33, d); chk("R7 set alias reads 0", d, 32'h0);
        rd(6'd34, d); chk("R7 clear alias reads 0", d, 32'h0);

        // R6 software raise of line 10
        wr(6'd37, 32'h0);
        wr(6'd38, 32'h0000_0400);
        settle();
        chk_pkt("R6 soft raise", 1'b1, 32'h1050, 6'd9, 6'd1, 1'b0);
        rd(6'd37, d); chk("R6 soft readback", d, 32'h400);
        rd(6'd38, d); chk("R7 soft set alias reads 0", d, 32'h0);
        rd(6'd41, d); chk("R5 status", d, 32'h8000_000A);
        rd(6'd43, d); chk("R5 address word", d, 32'h1050);

        // R10 write latency and R4 entry sizes
        wr(6'd40, 32'h3);
        chk("R10 old addr after write edge", req_addr, 32'h1050);
        settle();
        chk("R4 entry 32", req_addr, 32'h1140);
        wr(6'd40, 32'hFF);
        settle();
        chk("R4 entry 512", req_addr, 32'h2400);
        rd(6'd40, d); chk("R7 ctrl mask", d, 32'h7);
        wr(6'd40, 32'h1);
        settle();

        // R1 pending and raw views
        @(negedge clk) irq_lines = 32'h0000_0009;
        settle(); settle();
        rd(6'd36, d); chk("R7 raw status", d, 32'h9);
        rd(6'd35, d); chk("R1 pending", d, 32'h400);
        chk("R1 disabled lines ignored", req_addr, 32'h1050);

        // R8 ignored writes
        wr(6'd35, 32'hFFFF_FFFF);
        wr(6'd36, 32'hFFFF_FFFF);
        wr(6'd41, 32'hFFFF_FFFF);
        wr(6'd43, 32'hFFFF_FFFF);
        wr(6'd50, 32'hFFFF_FFFF);
        settle();
        rd(6'd32, d); chk("R8 enable kept", d, 32'h400);
        rd(6'd37, d); chk("R8 soft kept", d, 32'h400);
        rd(6'd42, d); chk("R8 base kept", d, 32'h1000);
        rd(6'd50, d); chk("R7 unmapped reads 0", d, 32'h0);
        chk_pkt("R8 packet kept", 1'b1, 32'h1050, 6'd9, 6'd1, 1'b0);

        // R5 no winner
        wr(6'd39, 32'h0000_0400);
        settle();
        chk_pkt("R5 idle packet", 1'b0, 32'h0, 6'd0, 6'd0, 1'b0);
        rd(6'd41, d); chk("R5 idle status", d, 32'h0);
        rd(6'd43, d); chk("R5 idle address", d, 32'h0);

        // R9 reset mid-operation
        wr(6'd38, 32'h0000_0400);
        settle();
        @(negedge clk) rst = 1'b1;
        settle();
        @(negedge clk) rst = 1'b0;
        chk_pkt("R9 reset again", 1'b0, 32'h0, 6'd0, 6'd0, 1'b0);
        rd(6'd32, d); chk("R9 enable cleared", d, 32'h0);
        rd(6'd3,  d); chk("R9 cfg cleared", d, 32'h0);
        rd(6'd37, d); chk("R9 soft cleared", d, 32'h0);
        rd(6'd40, d); chk("R9 ctrl cleared", d, 32'h0);
        rd(6'd42, d); chk("R9 base cleared", d, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule